// File: doc/BRIEF.md
# UART Transmit Byte Queue with Fill-Level Watermark

This block buffers outgoing bytes between software and a UART serializer. Each write to the transmit-data register arrives as a single-cycle push strobe carrying one byte. The serializer takes bytes from the head of the queue with a pop strobe, and the head byte is always visible on the read port. The storage is a circular buffer of `DEPTH` bytes, 32 by default. A read pointer and a write pointer each wrap around the buffer.

The block keeps a fill count and derives several outputs from it. It drives the full and empty flags, a sticky watermark flag set against a programmable threshold, and single-cycle pulses for drained-to-empty and dropped-byte overflow. It also assembles an 8-bit status word. In that word the transmit bits sit beside registered copies of the receive-side idle, empty and full indications supplied by the receive path. A flush input, driven from the software FIFO-reset control, empties the queue at once.

Top module: `uart_txq`

## Requirements
- R1: Bytes leave in the order they were accepted: `rd_byte_o` shows the oldest stored byte whenever the queue is not empty, and a pop advances to the next one.
- R2: A push while the queue holds `DEPTH` bytes and no pop is accepted in the same cycle drops the byte and leaves the level at `DEPTH`. `overflow_o` is high for exactly the cycle after that push.
- R3: The full flag (status bit 0) is 1 exactly while the level equals `DEPTH` and returns to 0 in the cycle after the first pop from a full queue.
- R4: The empty flag (status bit 2) clears in the cycle after the first accepted push. When a pop without a push brings the level from 1 to 0, the flag sets and `empty_evt_o` is high for that one following cycle.
- R5: `wm_o` sets after an accepted push that leaves the level at or above `wm_thr_i`. It clears after a pop without a push that leaves the level below `wm_thr_i`. In every other cycle it holds its value.
- R6: `txrst_i` forces the level to 0, sets the empty flag and clears `wm_o` in the next cycle. It takes priority over a push or pop in the same cycle, and it raises neither `empty_evt_o` nor `overflow_o`.
- R7: `level_o` carries the low 5 bits of the level, so a full 32-byte queue reads 0 there while the full flag is 1.
- R8: The status word holds transmit-full in bit 0, receive-full in bit 1, transmit-empty in bit 2, transmit-idle in bit 3, receive-idle in bit 4 and receive-empty in bit 5; bits 7:6 are 0. It reads 0x3C during and right after reset. The receive bits are the receive inputs registered one cycle. Transmit-idle is the previous cycle's (empty AND NOT `ser_busy_i`).
- R9: A push and a pop in the same cycle on a non-empty queue leave the level unchanged and never flag overflow, even when full. The pushed byte is stored at the tail.
- R10: A pop on an empty queue is ignored: the level stays 0 and no `empty_evt_o` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Push strobe from the transmit-data register write |
| wr_byte_i | input | 8 | Byte to push |
| rd_en_i | input | 1 | Pop strobe from the serializer |
| rd_byte_o | output | 8 | Head byte of the queue |
| txrst_i | input | 1 | Flush request from the FIFO-reset control |
| wm_thr_i | input | 5 | Watermark threshold |
| ser_busy_i | input | 1 | Serializer is shifting a byte |
| rx_full_i | input | 1 | Receive path full indication |
| rx_idle_i | input | 1 | Receive path idle indication |
| rx_empty_i | input | 1 | Receive path empty indication |
| level_o | output | 5 | Low 5 bits of the fill level |
| status_o | output | 8 | Status word |
| wm_o | output | 1 | Watermark flag |
| empty_evt_o | output | 1 | Drained-to-empty pulse |
| overflow_o | output | 1 | Dropped-byte pulse |

## Verification
The bound checker checks cycle-local relations on every cycle: the full flag with the level field, the one-cycle overflow and empty pulses and their causes, the effect of a flush one cycle later, the no-overflow rule for a combined push and pop on a full queue, and that a rising watermark follows a push. Only the bench's scenarios can show byte ordering through pointer wrap-around, the exact watermark set and clear points under changing thresholds, and the registered status word contents. Both are checked against a queue model over long random sequences.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
    // Byte width carried through the queue
    localparam int BYTE_W = 8;
    // Width of the status word and bit positions inside it
    localparam int STAT_W       = 8;
    localparam int ST_TX_FULL   = 0;
    localparam int ST_RX_FULL   = 1;
    localparam int ST_TX_EMPTY  = 2;
    localparam int ST_TX_IDLE   = 3;
    localparam int ST_RX_IDLE   = 4;
    localparam int ST_RX_EMPTY  = 5;
    // Value of the status word while in reset
    localparam logic [STAT_W-1:0] STAT_RST = 8'h3C;

    // Pointer-width helper: bits needed to index a buffer of the given depth
    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/uart_txq_ptr.sv
// Wrapping pointer for the circular buffer.
// Assumes: advance is only asserted when the owning side is allowed to move.
// A power-of-two depth wraps naturally; other depths compare against the end.
module uart_txq_ptr #(
    parameter int DEPTH = 32,
    parameter int PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [PTR_W-1:0] ptr
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    logic [PTR_W-1:0] ptr_inc;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            // Natural binary wrap
            always_comb ptr_inc = ptr + 1'b1;
        end else begin : g_cmp
            // Explicit wrap at the last slot
            always_comb ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    endgenerate

    // Pointer register: reset or clear to slot 0, else step on advance
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ptr <= '0;
        else if (advance)    ptr <= ptr_inc;
    end
endmodule

// File: rtl/uart_txq_store.sv
// Byte storage array: one write port, one asynchronous read port.
// Assumes: the controller never writes a slot that holds an unread byte.
module uart_txq_store #(
    parameter int DEPTH = 32,
    parameter int PTR_W = 5,
    parameter int W     = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] mem [DEPTH];

    // Write the pushed byte into its slot
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Head byte is visible without a read latency
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/uart_txq_level.sv
// Fill-level counter with full/empty flags, watermark flag and event pulses.
// Assumes: push/pop/flush requests are single-cycle qualified strobes.
// Flush wins over push and pop; a pop on empty is ignored; a push on full
// is dropped unless a pop is accepted in the same cycle.
module uart_txq_level #(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6,
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             flush,
    input  logic [THR_W-1:0] thr,
    output logic             do_push,
    output logic             do_pop,
    output logic [LVL_W-1:0] lvl,
    output logic             full,
    output logic             empty,
    output logic             wm,
    output logic             empty_evt,
    output logic             ovf
);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [LVL_W-1:0] lvl_n;
    logic [LVL_W-1:0] thr_ext;
    logic             drop;
    logic             wm_n;

    // Qualify the raw requests against current occupancy
    always_comb begin
        do_pop  = pop_req & ~empty & ~flush;
        do_push = push_req & ~flush & (~full | do_pop);
        drop    = push_req & ~flush & full & ~do_pop;
    end

    // Next fill level
    always_comb begin
        if (flush)                  lvl_n = '0;
        else if (do_push & ~do_pop) lvl_n = lvl + 1'b1;
        else if (do_pop & ~do_push) lvl_n = lvl - 1'b1;
        else                        lvl_n = lvl;
    end

    // Next watermark state: set on a qualifying push, clear on a draining pop
    always_comb begin
        thr_ext = LVL_W'(thr);
        wm_n    = wm;
        if (flush)                                         wm_n = 1'b0;
        else if (do_push && lvl_n >= thr_ext)              wm_n = 1'b1;
        else if (do_pop && !do_push && lvl_n < thr_ext)    wm_n = 1'b0;
    end

    // Level and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl   <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
            wm    <= 1'b0;
        end else begin
            lvl   <= lvl_n;
            full  <= (lvl_n == LVL_MAX);
            empty <= (lvl_n == '0);
            wm    <= wm_n;
        end
    end

    // Single-cycle event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_evt <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            empty_evt <= ~flush & do_pop & ~do_push & (lvl == LVL_W'(1));
            ovf       <= drop;
        end
    end
endmodule

// File: rtl/uart_txq_status.sv
// Status word assembly: registered receive indications and transmit idle.
// Assumes: the receive inputs are synchronous to clk.
module uart_txq_status
    import uart_txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              ser_busy,
    input  logic              rx_full,
    input  logic              rx_idle,
    input  logic              rx_empty,
    output logic [STAT_W-1:0] word
);
    logic tx_idle_q, rx_full_q, rx_idle_q, rx_empty_q;

    // Register the side indications; reset to the idle/empty state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_idle_q  <= STAT_RST[ST_TX_IDLE];
            rx_full_q  <= STAT_RST[ST_RX_FULL];
            rx_idle_q  <= STAT_RST[ST_RX_IDLE];
            rx_empty_q <= STAT_RST[ST_RX_EMPTY];
        end else begin
            tx_idle_q  <= tx_empty & ~ser_busy;
            rx_full_q  <= rx_full;
            rx_idle_q  <= rx_idle;
            rx_empty_q <= rx_empty;
        end
    end

    // Place each bit at its position in the word
    always_comb begin
        word              = '0;
        word[ST_TX_FULL]  = tx_full;
        word[ST_RX_FULL]  = rx_full_q;
        word[ST_TX_EMPTY] = tx_empty;
        word[ST_TX_IDLE]  = tx_idle_q;
        word[ST_RX_IDLE]  = rx_idle_q;
        word[ST_RX_EMPTY] = rx_empty_q;
    end
endmodule

// File: rtl/uart_txq.sv
// Transmit byte queue for a UART: circular buffer, fill level, watermark,
// events and status word.
// Assumes: one push and one pop strobe per cycle at most; txrst_i is a
// single-cycle strobe from the FIFO-reset control write.
module uart_txq
    import uart_txq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int LVLF_W  = 5,
    parameter int THR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    input  logic              txrst_i,
    input  logic [THR_W-1:0]  wm_thr_i,
    input  logic              ser_busy_i,
    input  logic              rx_full_i,
    input  logic              rx_idle_i,
    input  logic              rx_empty_i,
    output logic [LVLF_W-1:0] level_o,
    output logic [STAT_W-1:0] status_o,
    output logic              wm_o,
    output logic              empty_evt_o,
    output logic              overflow_o
);
    localparam int PTR_W = ptr_bits(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic             do_push, do_pop;
    logic [PTR_W-1:0] wptr, rptr;
    logic [LVL_W-1:0] lvl;
    logic             full, empty;

    uart_txq_level #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) u_level (
        .clk(clk), .rst_n(rst_n),
        .push_req(wr_en_i), .pop_req(rd_en_i), .flush(txrst_i), .thr(wm_thr_i),
        .do_push(do_push), .do_pop(do_pop), .lvl(lvl),
        .full(full), .empty(empty), .wm(wm_o),
        .empty_evt(empty_evt_o), .ovf(overflow_o)
    );

    uart_txq_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wptr (
        .clk(clk), .rst_n(rst_n), .clear(txrst_i), .advance(do_push), .ptr(wptr)
    );

    uart_txq_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clear(txrst_i), .advance(do_pop), .ptr(rptr)
    );

    uart_txq_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .W(BYTE_W)) u_store (
        .clk(clk), .we(do_push), .waddr(wptr), .wdata(wr_byte_i),
        .raddr(rptr), .rdata(rd_byte_o)
    );

    uart_txq_status u_status (
        .clk(clk), .rst_n(rst_n),
        .tx_full(full), .tx_empty(empty), .ser_busy(ser_busy_i),
        .rx_full(rx_full_i), .rx_idle(rx_idle_i), .rx_empty(rx_empty_i),
        .word(status_o)
    );

    // Expose the low bits of the level as the readable field
    always_comb level_o = lvl[LVLF_W-1:0];
endmodule

// File: rtl/uart_txq_chk.sv
// Protocol checker for uart_txq, attached by bind.
// Assumes: observes top-level ports only; default 32-deep configuration.
module uart_txq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic       rd_en_i,
    input logic       txrst_i,
    input logic [4:0] level_o,
    input logic [7:0] status_o,
    input logic       wm_o,
    input logic       empty_evt_o,
    input logic       overflow_o
);
    // Full flag implies the level field wraps to 0 and the queue is not empty
    p_full_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |-> (level_o == 5'd0 && !status_o[2]));

    // Overflow pulse follows a push on a full queue with no pop or flush
    p_overflow_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> $past(wr_en_i && status_o[0] && !rd_en_i && !txrst_i));

    // Empty event coincides with the empty flag having just set
    p_empty_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        empty_evt_o |-> (status_o[2] && $past(!status_o[2])));

    // Flush leaves an empty queue with no watermark and no events
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        txrst_i |=> (status_o[2] && level_o == 5'd0 && !wm_o && !empty_evt_o && !overflow_o));

    // Push with pop on a full queue keeps it full and raises no overflow
    p_pushpop_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && wr_en_i && rd_en_i && !txrst_i) |=> (status_o[0] && !overflow_o));

    // Watermark only rises after a push
    p_wm_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wm_o) |-> $past(wr_en_i));

    // Status bits 7:6 never set
    p_status_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:6] == 2'b00);
endmodule

bind uart_txq uart_txq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .txrst_i(txrst_i), .level_o(level_o), .status_o(status_o), .wm_o(wm_o),
    .empty_evt_o(empty_evt_o), .overflow_o(overflow_o)
);

// File: tb/uart_txq_tb.sv
module uart_txq_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en_i, rd_en_i, txrst_i, ser_busy_i;
    logic       rx_full_i, rx_idle_i, rx_empty_i;
    logic [7:0] wr_byte_i, rd_byte_o, status_o;
    logic [4:0] wm_thr_i, level_o;
    logic       wm_o, empty_evt_o, overflow_o;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    byte unsigned mq[$];
    bit m_wm, m_evt, m_ovf, m_txidle, m_rxf, m_rxi, m_rxe;

    always #10 clk = ~clk;

    uart_txq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_byte_i(wr_byte_i),
        .rd_en_i(rd_en_i), .rd_byte_o(rd_byte_o), .txrst_i(txrst_i),
        .wm_thr_i(wm_thr_i), .ser_busy_i(ser_busy_i), .rx_full_i(rx_full_i),
        .rx_idle_i(rx_idle_i), .rx_empty_i(rx_empty_i), .level_o(level_o),
        .status_o(status_o), .wm_o(wm_o), .empty_evt_o(empty_evt_o),
        .overflow_o(overflow_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        int n = mq.size();
        return {2'b00, m_rxe, m_rxi, m_txidle, (n == 0), m_rxf, (n == 32)};
    endfunction

    // Compare every output against the model (called away from the edge)
    task automatic compare_all(input string tag);
        chk({tag, " R7 level"}, level_o, mq.size() % 32);
        chk({tag, " R8 status"}, status_o, exp_status());
        chk({tag, " R5 wm"}, wm_o, m_wm);
        chk({tag, " R4 empty_evt"}, empty_evt_o, m_evt);
        chk({tag, " R2 overflow"}, overflow_o, m_ovf);
    endtask

    // One cycle: drive at negedge, check head, clock, update model, compare
    task automatic step(input bit wr, input byte unsigned d, input bit rd,
                        input bit fl, input string tag);
        bit was_empty, push_ok, pop_ok;
        int n;
        wr_en_i = wr; wr_byte_i = d; rd_en_i = rd; txrst_i = fl;
        #1;
        n = mq.size();
        if (rd && n > 0 && !fl) chk({tag, " R1 head"}, rd_byte_o, mq[0]);
        @(posedge clk);
        was_empty = (n == 0);
        pop_ok  = rd && n > 0 && !fl;
        push_ok = wr && !fl && (n < 32 || pop_ok);
        m_ovf   = wr && !fl && n == 32 && !pop_ok;
        m_evt   = pop_ok && !push_ok && n == 1;
        m_txidle = was_empty && !ser_busy_i;
        m_rxf = rx_full_i; m_rxi = rx_idle_i; m_rxe = rx_empty_i;
        if (fl) begin
            mq.delete();
            m_wm = 0;
        end else begin
            if (pop_ok)  void'(mq.pop_front());
            if (push_ok) mq.push_back(d);
            if (push_ok && mq.size() >= wm_thr_i) m_wm = 1;
            else if (pop_ok && !push_ok && mq.size() < wm_thr_i) m_wm = 0;
        end
        @(negedge clk);
        compare_all(tag);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en_i = 0; rd_en_i = 0; txrst_i = 0; wr_byte_i = 0;
        wm_thr_i = 5'd4; ser_busy_i = 0;
        rx_full_i = 0; rx_idle_i = 1; rx_empty_i = 1;
        m_wm = 0; m_evt = 0; m_ovf = 0; m_txidle = 1; m_rxf = 0; m_rxi = 1; m_rxe = 1;
        repeat (3) @(negedge clk);
        chk("R8 reset status", status_o, 8'h3C);
        rst_n = 1;
        @(negedge clk);
        chk("R8 status after reset", status_o, 8'h3C);
        compare_all("reset");

        // R10: pop on empty ignored
        step(0, 0, 1, 0, "R10 pop empty");
        chk("R10 no event", empty_evt_o, 0);

        // R1/R3/R5/R7: fill to capacity with threshold 4
        for (int i = 0; i < 32; i++) step(1, byte'(8'h40 + i), 0, 0, "R3 fill");
        chk("R3 full bit", status_o[0], 1);
        chk("R7 full reads zero", level_o, 0);
        chk("R5 wm set", wm_o, 1);

        // R2: overflow while full
        step(1, 8'hEE, 0, 0, "R2 drop");
        chk("R2 overflow pulse", overflow_o, 1);
        step(0, 0, 0, 0, "R2 pulse ends");

        // R9: push+pop when full
        step(1, 8'hA5, 1, 0, "R9 pushpop full");
        chk("R9 still full", status_o[0], 1);
        chk("R9 no overflow", overflow_o, 0);

        // R3: first pop clears full
        step(0, 0, 1, 0, "R3 unfull");
        chk("R3 full cleared", status_o[0], 0);

        // R4/R5: drain to empty; wm clears below threshold
        for (int i = 0; i < 31; i++) step(0, 0, 1, 0, "R4 drain");
        chk("R4 empty event", empty_evt_o, 1);
        chk("R5 wm cleared", wm_o, 0);
        step(0, 0, 0, 0, "R4 evt ends");

        // R6: flush with concurrent push beats both
        for (int i = 0; i < 6; i++) step(1, byte'(i), 0, 0, "R6 prefill");
        step(1, 8'h99, 1, 1, "R6 flush");
        chk("R6 level zero", level_o, 0);
        chk("R6 wm cleared", wm_o, 0);
        chk("R6 no event", empty_evt_o, 0);

        // R5: threshold 0 sets on first push and stays
        wm_thr_i = 5'd0;
        step(1, 8'h11, 0, 0, "R5 thr0");
        chk("R5 thr0 set", wm_o, 1);
        step(0, 0, 1, 0, "R5 thr0 hold");
        chk("R5 thr0 holds", wm_o, 1);

        // R8: side inputs and serializer busy
        ser_busy_i = 1; rx_full_i = 1; rx_idle_i = 0; rx_empty_i = 0;
        step(0, 0, 0, 0, "R8 side");
        step(0, 0, 0, 0, "R8 side2");

        // Random phase
        void'($urandom(32'd2024));
        for (int i = 0; i < 4000; i++) begin
            int ph = (i / 200) % 2;
            bit w = ($urandom % 100) < (ph ? 35 : 70);
            bit r = ($urandom % 100) < (ph ? 70 : 35);
            bit f = ($urandom % 200) == 0;
            if (($urandom % 50) == 0) wm_thr_i = 5'($urandom);
            ser_busy_i = 1'($urandom); rx_full_i = 1'($urandom);
            rx_idle_i = 1'($urandom); rx_empty_i = 1'($urandom);
            step(w, byte'($urandom), r, f, "RND R1 R9");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule